// File: doc/BRIEF.md
# BCD One-of-Ten Decoder and Demultiplexer

This block turns a four-bit binary-coded-decimal digit into ten output lines. Exactly one line sits at the active level and the rest sit at the idle level. A run-time polarity input selects what the active level is. When the polarity input is 0 the chosen line is 1 and the others are 0. When it is 1 the chosen line is 0 and the others are 1. Digits above nine select nothing, so every line stays idle.

Two gating inputs of opposite sense can force every line to idle: `gate_n` is active low and `gate_p` is active high. A data stream fed into either gate therefore lands on the addressed line. Through `gate_p` the data arrives true, and through `gate_n` it arrives inverted, so the block also works as a one-to-ten demultiplexer. A float control releases all ten pins to high impedance. The decoded vector stays visible on a separate port, so the logic can be observed without tri-state resolution. The block is purely combinational and has no clock or reset.

Top module: `bcd_demux10`

## Requirements
- R1: With polarity 0, both gates open and digit d in 0..9, `dec_out` bit d is 1 and every other bit is 0.
- R2: With polarity 1, both gates open and digit d in 0..9, `dec_out` bit d is 0 and every other bit is 1.
- R3: Digit codes 10 to 15 put all ten bits of `dec_out` at the polarity value, whatever the gates are.
- R4: `gate_n` at 1 puts all ten bits of `dec_out` at the polarity value.
- R5: `gate_p` at 0 puts all ten bits of `dec_out` at the polarity value.
- R6: `float_pins` at 1 clears `pin_drive` and releases `pin_out` to high impedance, for every other input. `dec_out` is left unchanged by `float_pins`.
- R7: `float_pins` at 0 sets `pin_drive`, and `pin_out` then equals `dec_out`.
- R8: For every input combination, at most one bit of `dec_out` differs from the polarity value.
- R9: With the other gate held open and polarity 0, data on `gate_p` appears true on the addressed line, and data on `gate_n` appears inverted on it. All other lines stay idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit | input | 4 | BCD address; codes 0..9 select a line |
| polarity | input | 1 | 0: selected line high; 1: selected line low |
| gate_n | input | 1 | Active-low gate; 1 forces all lines idle |
| gate_p | input | 1 | Active-high gate; 0 forces all lines idle |
| float_pins | input | 1 | 1 releases `pin_out` to high impedance |
| dec_out | output | 10 | Decoded levels before the tri-state stage |
| pin_drive | output | 1 | 1 while `pin_out` is being driven |
| pin_out | output | 10 | Tri-state output lines |

## Verification
The bench builds the block with its default parameters: ten lines and a four-bit digit. With those values it can reach all 256 combinations of digit, polarity, both gates and the float control. It also exercises the six unused codes above nine, which a generic decoder could otherwise map onto phantom lines. The demultiplexer scenarios toggle one gate as data while the digit walks through all ten lines.

// File: rtl/bcd_dec_pkg.sv
package bcd_dec_pkg;
  localparam int unsigned DEF_LINES = 10;

  function automatic int unsigned addr_bits(input int unsigned lines);
    return (lines < 2) ? 1 : $clog2(lines);
  endfunction
endpackage

// File: rtl/bcd_addr_decode.sv
module bcd_addr_decode #(
  parameter int unsigned LINES  = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LINES-1:0]  sel,
  output logic              in_range
);
  // one comparator per line; codes at or above LINES match none
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign sel[i] = (addr == ADDR_W'(i));
  end

  assign in_range = ({1'b0, addr} < (ADDR_W+1)'(LINES));

  always_comb begin
    if (!in_range) begin
      assert_range_idle_R3: assert (sel == '0)
        else $error("code above last line selected a line");
    end
  end
endmodule

// File: rtl/bcd_level_map.sv
module bcd_level_map #(
  parameter int unsigned LINES = 10
) (
  input  logic [LINES-1:0] sel,
  input  logic             polarity,
  input  logic             gate_n,
  input  logic             gate_p,
  output logic [LINES-1:0] level
);
  logic open;

  assign open  = gate_p & ~gate_n;
  assign level = {LINES{polarity}} ^ (sel & {LINES{open}});

  always_comb begin
    if (gate_n || !gate_p) begin
      assert_gate_idle_R4: assert (level == {LINES{polarity}})
        else $error("closed gate let a line go active");
    end
  end
endmodule

// File: rtl/bcd_demux10.sv
module bcd_demux10 #(
  parameter int unsigned LINES  = bcd_dec_pkg::DEF_LINES,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] digit,
  input  logic              polarity,
  input  logic              gate_n,
  input  logic              gate_p,
  input  logic              float_pins,
  output logic [LINES-1:0]  dec_out,
  output logic              pin_drive,
  output wire  [LINES-1:0]  pin_out
);
  localparam int unsigned MIN_ADDR_W = bcd_dec_pkg::addr_bits(LINES);

  logic [LINES-1:0] sel;
  logic             in_range;

  bcd_addr_decode #(.LINES(LINES), .ADDR_W(ADDR_W)) u_decode (
    .addr     (digit),
    .sel      (sel),
    .in_range (in_range)
  );

  bcd_level_map #(.LINES(LINES)) u_level (
    .sel      (sel),
    .polarity (polarity),
    .gate_n   (gate_n),
    .gate_p   (gate_p),
    .level    (dec_out)
  );

  // float control outranks every decode path
  assign pin_drive = ~float_pins;
  assign pin_out   = pin_drive ? dec_out : {LINES{1'bz}};

  initial begin
    assert_addr_width_fit: assert (ADDR_W >= MIN_ADDR_W)
      else $error("digit width too narrow for line count");
  end

  always_comb begin
    assert_single_active_R8: assert ($countones(dec_out ^ {LINES{polarity}}) <= 1)
      else $error("more than one line active");
    if (!in_range) begin
      assert_oor_idle_R3: assert (dec_out == {LINES{polarity}})
        else $error("out-of-range code reached a line");
    end
    if (!float_pins) begin
      assert_pin_follow_R7: assert (pin_drive)
        else $error("pins not driven while enabled");
    end
  end
endmodule

// File: tb/test_bcd_demux10.sv
module test_bcd_demux10;
  logic       clk = 1'b0;
  logic [3:0] digit = '0;
  logic       polarity = 1'b0;
  logic       gate_n = 1'b1;
  logic       gate_p = 1'b0;
  logic       float_pins = 1'b0;
  logic [9:0] dec_out;
  logic       pin_drive;
  wire  [9:0] pin_out;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cycles = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  bcd_demux10 i_bcd_demux10 (
    .digit(digit), .polarity(polarity), .gate_n(gate_n), .gate_p(gate_p),
    .float_pins(float_pins), .dec_out(dec_out), .pin_drive(pin_drive),
    .pin_out(pin_out)
  );

  function automatic logic [9:0] model(input logic [3:0] d, input logic p,
                                       input logic gn, input logic gp);
    logic [9:0] v;
    v = {10{p}};
    if (gp && !gn && d <= 4'd9) v[d] = ~p;
    return v;
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] d, input logic p, input logic gn,
                       input logic gp, input logic fz);
    digit = d; polarity = p; gate_n = gn; gate_p = gp; float_pins = fz;
    #1;
  endtask

  task automatic t_idle_state;
    apply(4'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 initial idle", dec_out, 10'h000);
    chk("R7 initial pins", pin_out, 10'h000);
  endtask

  task automatic t_active_high;
    for (int d = 0; d < 10; d++) begin
      apply(4'(d), 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R1 active high", dec_out, 10'(1 << d));
    end
  endtask

  task automatic t_active_low;
    for (int d = 0; d < 10; d++) begin
      apply(4'(d), 1'b1, 1'b0, 1'b1, 1'b0);
      chk("R2 active low", dec_out, ~10'(1 << d));
    end
  endtask

  task automatic t_out_of_range;
    for (int d = 10; d < 16; d++) begin
      for (int p = 0; p < 2; p++) begin
        apply(4'(d), 1'(p), 1'b0, 1'b1, 1'b0);
        chk("R3 code above nine", dec_out, {10{1'(p)}});
      end
    end
  endtask

  task automatic t_gates;
    for (int p = 0; p < 2; p++) begin
      apply(4'd5, 1'(p), 1'b1, 1'b1, 1'b0);
      chk("R4 gate_n high", dec_out, {10{1'(p)}});
      apply(4'd5, 1'(p), 1'b0, 1'b0, 1'b0);
      chk("R5 gate_p low", dec_out, {10{1'(p)}});
    end
  endtask

  task automatic t_float;
    apply(4'd3, 1'b0, 1'b0, 1'b1, 1'b1);
    n_chk++;
    if (pin_drive !== 1'b0 || !(pin_out === 10'bz || pin_out === 10'h000)) begin
      n_bad++;
      $display("FAIL R6 float: actual drive %b pins %b expected drive 0 pins z", pin_drive, pin_out);
    end
    chk("R6 dec_out unaffected by float", dec_out, 10'h008);
    apply(4'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 pins follow", pin_out, ~10'h008);
  endtask

  task automatic t_demux;
    for (int d = 0; d < 10; d++) begin
      for (int b = 0; b < 2; b++) begin
        apply(4'(d), 1'b0, 1'b0, 1'(b), 1'b0);
        chk("R9 data on gate_p", dec_out, b ? 10'(1 << d) : 10'h000);
        apply(4'(d), 1'b0, 1'(b), 1'b1, 1'b0);
        chk("R9 data on gate_n", dec_out, b ? 10'h000 : 10'(1 << d));
      end
    end
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 256; c++) begin
      logic [9:0] e;
      apply(c[3:0], c[4], c[5], c[6], c[7]);
      e = model(c[3:0], c[4], c[5], c[6]);
      chk("R8 sweep decode", dec_out, e);
      n_chk++;
      if ($countones(dec_out ^ {10{c[4]}}) > 1) begin
        n_bad++;
        $display("FAIL R8 one active: actual %b expected at most one off %b", dec_out, {10{c[4]}});
      end
      n_chk++;
      if (pin_drive !== ~c[7]) begin
        n_bad++;
        $display("FAIL R6 drive: actual %b expected %b", pin_drive, ~c[7]);
      end
      if (!c[7]) chk("R7 sweep pins", pin_out, e);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_idle_state();
    t_active_high();
    t_active_low();
    t_out_of_range();
    t_gates();
    t_float();
    t_demux();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule